// File: doc/BRIEF.md
# Dual-Mode Serial Configuration Register

This block is the serial configuration front end of a 16-channel LED output driver. A host drives a serial clock, a data line, a latch strobe and a mode select. The mode select steers the serial port to one of two shift paths. The first is a 16-bit path that carries one enable bit per channel. The second is a 112-bit path that carries a 7-bit brightness-trim word for each channel. A rising edge on the latch strobe copies the selected shift path into its holding latch. The latched values are the block's parallel outputs.

In enable mode, the same latch edge also loads the open-LED status vector into the 16-bit shift path. The host then reads the status back on the serial output while it shifts the next enable word in. The serial output always carries the last stage of the selected path, so several devices can be chained.

All logic runs on one system clock. The serial clock, the data line, the strobe and the mode select pass through synchronizer stages, and the block detects their rising edges there. The system clock must run at least four times faster than the serial clock.

Top module: `led_cfg_frontend`

## Requirements
- R1: While reset is asserted, and after its release, both shift paths, both latches and `ser_dout` read 0 until the first serial or strobe edge.
- R2: With `mode_sel` low, each rising `ser_clk` edge shifts `ser_din` into bit 0 of the 16-bit enable path. The first bit sent ends in bit 15, which is channel 15.
- R3: With `mode_sel` high, each rising `ser_clk` edge shifts `ser_din` into bit 0 of the 112-bit trim path, most significant bit first. Channel x occupies bits 7x+6 down to 7x of `dc_q`, so channel 15 is bits 111..105.
- R4: A rising `latch_en` edge copies only the path that `mode_sel` selects into its latch. The other latch keeps its value.
- R5: In enable mode, the latch edge also loads `open_stat` into the enable path, where bit x is 1 when channel x is open. The next 16 shifts present that vector on `ser_dout`, bit 15 first.
- R6: `ser_dout` shows bit 15 of the enable path when `mode_sel` is low and bit 111 of the trim path when it is high. A bit therefore leaves 16 shifts later in enable mode and 112 shifts later in trim mode. Changing `mode_sel` changes the source of `ser_dout` without further serial edges.
- R7: Shifting does not alter `onoff_q` or `dc_q` between latch edges.
- R8: When a serial clock edge and a latch edge are detected in the same cycle, the latch takes the contents from before that shift. In enable mode the status load takes precedence over the shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; clears all state |
| ser_clk | input | 1 | Serial shift clock; acts on its rising edge |
| ser_din | input | 1 | Serial data in, MSB first |
| latch_en | input | 1 | Latch strobe; acts on its rising edge |
| mode_sel | input | 1 | 0 selects the enable path, 1 selects the trim path |
| open_stat | input | 16 | Open-LED status per channel, held by the output stage |
| ser_dout | output | 1 | Last stage of the selected shift path |
| onoff_q | output | 16 | Latched channel enables, bit x is channel x |
| dc_q | output | 112 | Latched 7-bit trim words, channel x in bits 7x+6..7x |

## Verification
A shift and a latch transfer can fall in the same system cycle when the host raises the serial clock and the strobe together. The bench provokes this by raising `ser_clk` and `latch_en` at the same instant, after it has loaded a known enable word and presented a distinct status vector. The latched word must equal the word from before the edge. The status vector, read out by 16 further shifts, must arrive intact, which shows that the coinciding shift was dropped and the data bit that came with it was lost.

// File: rtl/led_cfg_frontend.sv
module led_cfg_frontend #(
  parameter int NCH  = 16,
  parameter int DCW  = 7,
  parameter int SYNC = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ser_clk,
  input  logic                 ser_din,
  input  logic                 latch_en,
  input  logic                 mode_sel,
  input  logic [NCH-1:0]       open_stat,
  output logic                 ser_dout,
  output logic [NCH-1:0]       onoff_q,
  output logic [NCH*DCW-1:0]   dc_q
);
  localparam int DCB = NCH * DCW;

  logic [SYNC:0]   sclk_p, le_p;
  logic [SYNC-1:0] din_p, mode_p;
  logic [NCH-1:0]  onoff_sr;
  logic [DCB-1:0]  dc_sr;

  wire sclk_rise = sclk_p[SYNC-1] & ~sclk_p[SYNC];
  wire le_rise   = le_p[SYNC-1] & ~le_p[SYNC];
  wire din_s     = din_p[SYNC-1];
  wire mode_s    = mode_p[SYNC-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_p <= '0;
      le_p   <= '0;
      din_p  <= '0;
      mode_p <= '0;
    end else begin
      sclk_p <= {sclk_p[SYNC-1:0], ser_clk};
      le_p   <= {le_p[SYNC-1:0], latch_en};
      din_p  <= {din_p[SYNC-2:0], ser_din};
      mode_p <= {mode_p[SYNC-2:0], mode_sel};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      onoff_sr <= '0;
      onoff_q  <= '0;
    end else if (!mode_s) begin
      if (le_rise) begin
        onoff_q  <= onoff_sr;
        onoff_sr <= open_stat;
      end else if (sclk_rise) begin
        onoff_sr <= {onoff_sr[NCH-2:0], din_s};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dc_sr <= '0;
      dc_q  <= '0;
    end else if (mode_s) begin
      if (le_rise)   dc_q  <= dc_sr;
      if (sclk_rise) dc_sr <= {dc_sr[DCB-2:0], din_s};
    end
  end

  assign ser_dout = mode_s ? dc_sr[DCB-1] : onoff_sr[NCH-1];
endmodule

module led_cfg_frontend_chk #(
  parameter int NCH = 16,
  parameter int DCB = 112
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sclk_rise,
  input logic           le_rise,
  input logic           mode_s,
  input logic           ser_dout,
  input logic [NCH-1:0] open_stat,
  input logic [NCH-1:0] onoff_sr,
  input logic [DCB-1:0] dc_sr,
  input logic [NCH-1:0] onoff_q,
  input logic [DCB-1:0] dc_q
);
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (onoff_q == '0 && dc_q == '0 && !ser_dout)); // R1
  AST_ONOFF_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && !le_rise && !mode_s) |=> onoff_sr[NCH-1] == $past(onoff_sr[NCH-2])); // R2
  AST_DC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && mode_s) |=> dc_sr[DCB-1] == $past(dc_sr[DCB-2])); // R3
  AST_DC_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && mode_s) |=> (dc_q == $past(dc_sr) && $stable(onoff_q))); // R4
  AST_STATUS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && !mode_s) |=> (onoff_sr == $past(open_stat) && $stable(dc_q))); // R5
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !le_rise |=> ($stable(onoff_q) && $stable(dc_q))); // R7
  AST_SIMUL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && sclk_rise && !mode_s) |=> onoff_q == $past(onoff_sr)); // R8
endmodule

bind led_cfg_frontend led_cfg_frontend_chk #(.NCH(NCH), .DCB(NCH*DCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .le_rise(le_rise),
  .mode_s(mode_s), .ser_dout(ser_dout), .open_stat(open_stat),
  .onoff_sr(onoff_sr), .dc_sr(dc_sr), .onoff_q(onoff_q), .dc_q(dc_q));

// File: tb/tb_led_cfg_frontend.sv
module tb_led_cfg_frontend;
  logic clk = 0, rst_n = 0;
  logic ser_clk = 0, ser_din = 0, latch_en = 0, mode_sel = 0;
  logic [15:0] open_stat = '0;
  logic ser_dout;
  logic [15:0] onoff_q;
  logic [111:0] dc_q;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  led_cfg_frontend dut (.clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .latch_en(latch_en), .mode_sel(mode_sel), .open_stat(open_stat),
    .ser_dout(ser_dout), .onoff_q(onoff_q), .dc_q(dc_q));

  typedef struct packed { logic [15:0] word; logic [15:0] open; } vec_t;
  localparam vec_t VECS [4] = '{
    '{16'hA5C3, 16'h0001}, '{16'h8001, 16'h8000},
    '{16'h1234, 16'hFFFF}, '{16'hFFFF, 16'h4002}};

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input logic b);
    ser_din = b; cyc(4); ser_clk = 1; cyc(4); ser_clk = 0;
  endtask

  task automatic shift(input logic [127:0] w, input int n, output logic [127:0] got);
    got = '0;
    for (int i = n - 1; i >= 0; i--) begin
      got = {got[126:0], ser_dout};
      sbit(w[i]);
    end
    cyc(6);
  endtask

  task automatic strobe();
    cyc(2); latch_en = 1; cyc(4); latch_en = 0; cyc(6);
  endtask

  task automatic set_mode(input logic m);
    mode_sel = m; cyc(6);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] got;
    logic [111:0] pw, qw;
    logic [15:0] prev;
    cyc(5);
    chk("R1 reset onoff_q", 128'(onoff_q), 0);
    chk("R1 reset dc_q", 128'(dc_q), 0);
    chk("R1 reset ser_dout", 128'(ser_dout), 0);
    rst_n = 1; cyc(4);
    chk("R1 after release ser_dout", 128'(ser_dout), 0);

    prev = '0;
    for (int v = 0; v < 4; v++) begin
      shift(128'(VECS[v].word), 16, got);
      chk("R5 status readout", got, 128'(prev));
      open_stat = VECS[v].open;
      strobe();
      chk("R2 onoff latched", 128'(onoff_q), 128'(VECS[v].word));
      chk("R4 dc latch untouched", 128'(dc_q), 0);
      prev = VECS[v].open;
    end
    shift(128'h0, 16, got);
    chk("R5 last status readout", got, 128'(prev));
    chk("R7 onoff_q held across shifts", 128'(onoff_q), 128'(16'hFFFF));

    for (int c = 0; c < 16; c++) begin
      pw[c*7 +: 7] = 7'((c * 5 + 3) & 127);
      qw[c*7 +: 7] = 7'((c * 9 + 100) & 127);
    end
    set_mode(1);
    shift(128'(pw), 112, got);
    strobe();
    chk("R3 dc_q full word", 128'(dc_q), 128'(pw));
    chk("R3 channel 15 field", 128'(dc_q[111:105]), 128'(7'd78));
    chk("R3 channel 0 field", 128'(dc_q[6:0]), 128'(7'd3));
    chk("R4 onoff latch untouched", 128'(onoff_q), 128'(16'hFFFF));
    shift(128'(qw), 112, got);
    chk("R6 112-shift delay on ser_dout", got, 128'(pw));
    chk("R7 dc_q held across shifts", 128'(dc_q), 128'(pw));
    strobe();
    chk("R4 dc_q second load", 128'(dc_q), 128'(qw));

    chk("R6 ser_dout from trim path", 128'(ser_dout), 1);
    set_mode(0);
    chk("R6 ser_dout from enable path", 128'(ser_dout), 0);

    shift(128'(16'hC3A5), 16, got);
    open_stat = 16'h0F0F;
    ser_din = 1; cyc(4);
    ser_clk = 1; latch_en = 1; cyc(4);
    ser_clk = 0; latch_en = 0; cyc(6);
    chk("R8 latch takes pre-shift word", 128'(onoff_q), 128'(16'hC3A5));
    shift(128'h0, 16, got);
    chk("R8 status load wins over shift", got, 128'(16'h0F0F));
    chk("R7 dc_q untouched in enable mode", 128'(dc_q), 128'(qw));

    set_mode(1);
    shift(128'h5A, 8, got);
    rst_n = 0; cyc(3);
    chk("R1 mid-run reset dc_q", 128'(dc_q), 0);
    chk("R1 mid-run reset onoff_q", 128'(onoff_q), 0);
    chk("R1 mid-run reset ser_dout", 128'(ser_dout), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule